// File: doc/BRIEF.md
# Dual Interval Countdown Timers

This block holds two 16-bit down counters behind a byte-wide register port. The first timer has a separately writable 16-bit reload latch. Writing its counter high byte copies the latch into the counter and starts it. A control bit lets this timer reload itself on each expiry, so it repeats. The second timer is a one-shot counter: a low-byte write loads it and halts it, and a high-byte write adds the upper byte and sets it running.

Both counters step down only on cycles where the tick-enable input is high. When a running counter is already at zero and sees a tick, it expires and sends a one-cycle expiry event to the interrupt logic. Register accesses that acknowledge an interrupt produce a per-timer flag-clear strobe in the same cycle as the access.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters, the reload latch and the control register read as 0x00, both timers are stopped, and the expiry and clear strobes are low.
- R2: Writes to offset 0x4 or 0x6 set the low byte of the reload latch. Reads of 0x6 and 0x7 return the latch low and high bytes and never raise a clear strobe.
- R3: A write to offset 0x7 sets the latch high byte and pulses the timer-1 clear strobe. It leaves the counter and the run state alone.
- R4: A write to offset 0x5 copies the whole latch into counter 1 (the written data is ignored), starts timer 1, and pulses the timer-1 clear strobe.
- R5: A running counter drops by exactly one on each cycle with tick-enable high, and holds its value when tick-enable is low.
- R6: A running one-shot counter that is at zero and sees a tick stays at zero and stops. Its expiry output is high for exactly the one cycle after that clock edge.
- R7: With bit 6 of the control register (offset 0xB) set, timer 1 reloads from the latch on every expiry instead of stopping, keeps running, and signals each expiry.
- R8: The control register reads back at 0xB. Writing it with bit 6 set starts timer 1 from the count it already holds.
- R9: A read of 0x4 returns counter 1 bits 7:0 and pulses the timer-1 clear strobe. A read of 0x5 returns bits 15:8 with no strobe.
- R10: A write to 0x8 loads counter 2 with zero-extended data and stops timer 2. A write to 0x9 adds data×256 to counter 2, starts it, and pulses the timer-2 clear strobe.
- R11: A read of 0x8 returns counter 2 bits 7:0 and pulses the timer-2 clear strobe. A read of 0x9 returns bits 15:8 with no strobe.
- R12: When a counter-loading write and a tick fall in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable, one pulse per system tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of the read |
| t1_ack | output | 1 | Timer-1 interrupt flag clear strobe |
| t2_ack | output | 1 | Timer-2 interrupt flag clear strobe |
| t1_expire | output | 1 | Timer-1 expiry event, one cycle |
| t2_expire | output | 1 | Timer-2 expiry event, one cycle |

## Verification
The counters are driven under several tick patterns: uninterrupted tick runs, gaps with no tick, ticks after a one-shot has stopped, and ticks coinciding with a load. Together these separate a decrement from a hold, a stop from a reload, and a load from a decrement. Expiry is checked one cycle after the zero-count tick and in the cycle after that. This catches events that fire early, never fire, or last too long. Register accesses are tried at every offset that has side effects, and the data and strobes are compared. This tells acknowledging accesses apart from side-effect-free read-backs, and starting writes apart from latch-only writes.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam logic [3:0] OFS_T1_CLO = 4'h4;
  localparam logic [3:0] OFS_T1_CHI = 4'h5;
  localparam logic [3:0] OFS_T1_LLO = 4'h6;
  localparam logic [3:0] OFS_T1_LHI = 4'h7;
  localparam logic [3:0] OFS_T2_LO  = 4'h8;
  localparam logic [3:0] OFS_T2_HI  = 4'h9;
  localparam logic [3:0] OFS_AUX    = 4'hB;
  localparam int unsigned AUX_CONT_BIT = 6;
  localparam int unsigned NUM_TIMERS   = 2;
endpackage

// File: rtl/dit_rst_sync.sv
module dit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_set,
  input  logic             run_clr,
  input  logic             cont_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             exp_d;
  logic             at_zero;

  assign at_zero = (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    run_d = running;
    exp_d = 1'b0;
    if (running && tick_en) begin
      if (at_zero) begin
        exp_d = 1'b1;
        if (cont_en) begin
          cnt_d = reload_val;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
    if (load_en) cnt_d = load_val;
    if (run_clr) run_d = 1'b0;
    if (run_set) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      running <= run_d;
      expire  <= exp_d;
    end
  end

  // R5: one step down per tick
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && !at_zero && !load_en |=> cnt == CNT_W'($past(cnt) - 1'b1));
  // R5: no tick, no load, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !load_en |=> $stable(cnt));
  // R6: one-shot expiry stops at zero
  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && at_zero && !cont_en && !load_en && !run_set
    |=> !running && cnt == '0 && expire);
  // R6: expiry only follows a zero-count tick
  a_r6_expire_cause: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(running && tick_en && at_zero));
  // R7: continuous reload
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick_en && at_zero && cont_en && !load_en && !run_clr
    |=> cnt == $past(reload_val) && running && expire);
  // R12: load beats tick
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt == $past(load_val));
endmodule

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [CNT_W-1:0]  cnt2,
  output logic [DATA_W-1:0] rdata,
  output logic              t1_load_en,
  output logic [CNT_W-1:0]  t1_load_val,
  output logic              t1_run_set,
  output logic              t1_cont,
  output logic [CNT_W-1:0]  t1_reload,
  output logic              t2_load_en,
  output logic [CNT_W-1:0]  t2_load_val,
  output logic              t2_run_set,
  output logic              t2_run_clr,
  output logic              t1_ack,
  output logic              t2_ack
);
  logic [CNT_W-1:0]  latch_q, latch_d;
  logic [DATA_W-1:0] aux_q, aux_d;
  logic w_clo, w_chi, w_llo, w_lhi, w_t2lo, w_t2hi, w_aux;
  logic r_clo, r_t2lo;

  assign w_clo  = wr_en && (addr == ADDR_W'(OFS_T1_CLO));
  assign w_chi  = wr_en && (addr == ADDR_W'(OFS_T1_CHI));
  assign w_llo  = wr_en && (addr == ADDR_W'(OFS_T1_LLO));
  assign w_lhi  = wr_en && (addr == ADDR_W'(OFS_T1_LHI));
  assign w_t2lo = wr_en && (addr == ADDR_W'(OFS_T2_LO));
  assign w_t2hi = wr_en && (addr == ADDR_W'(OFS_T2_HI));
  assign w_aux  = wr_en && (addr == ADDR_W'(OFS_AUX));
  assign r_clo  = rd_en && (addr == ADDR_W'(OFS_T1_CLO));
  assign r_t2lo = rd_en && (addr == ADDR_W'(OFS_T2_LO));

  always_comb begin
    latch_d = latch_q;
    aux_d   = aux_q;
    if (w_clo || w_llo) latch_d[DATA_W-1:0]     = wdata;
    if (w_lhi)          latch_d[CNT_W-1:DATA_W] = wdata;
    if (w_aux)          aux_d                   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      aux_q   <= '0;
    end else begin
      latch_q <= latch_d;
      aux_q   <= aux_d;
    end
  end

  assign t1_load_en  = w_chi;
  assign t1_load_val = latch_q;
  assign t1_run_set  = w_chi || (w_aux && wdata[AUX_CONT_BIT]);
  assign t1_cont     = aux_q[AUX_CONT_BIT];
  assign t1_reload   = latch_q;

  assign t2_load_en  = w_t2lo || w_t2hi;
  assign t2_load_val = w_t2hi ? (cnt2 + {wdata, {DATA_W{1'b0}}})
                              : {{DATA_W{1'b0}}, wdata};
  assign t2_run_set  = w_t2hi;
  assign t2_run_clr  = w_t2lo;

  assign t1_ack = w_chi || w_lhi || r_clo;
  assign t2_ack = w_t2hi || r_t2lo;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_W'(OFS_T1_CLO): rdata = cnt1[DATA_W-1:0];
        ADDR_W'(OFS_T1_CHI): rdata = cnt1[CNT_W-1:DATA_W];
        ADDR_W'(OFS_T1_LLO): rdata = latch_q[DATA_W-1:0];
        ADDR_W'(OFS_T1_LHI): rdata = latch_q[CNT_W-1:DATA_W];
        ADDR_W'(OFS_T2_LO):  rdata = cnt2[DATA_W-1:0];
        ADDR_W'(OFS_T2_HI):  rdata = cnt2[CNT_W-1:DATA_W];
        ADDR_W'(OFS_AUX):    rdata = aux_q;
        default:             rdata = '0;
      endcase
    end
  end

  // R2: latch low byte captured from either alias
  a_r2_latch_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clo || w_llo) |=> latch_q[DATA_W-1:0] == $past(wdata));
  // R8: control register holds written value
  a_r8_aux_store: assert property (@(posedge clk) disable iff (!rst_n)
    w_aux |=> aux_q == $past(wdata));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              t1_ack,
  output logic              t2_ack,
  output logic              t1_expire,
  output logic              t2_expire
);
  logic rst_core_n;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] ld_val, rl_val, cnt;
  logic [NUM_TIMERS-1:0] ld_en, run_set, run_clr, cont, running, expire;

  dit_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  dit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .cnt1(cnt[0]), .cnt2(cnt[1]), .rdata(rdata),
    .t1_load_en(ld_en[0]), .t1_load_val(ld_val[0]), .t1_run_set(run_set[0]),
    .t1_cont(cont[0]), .t1_reload(rl_val[0]),
    .t2_load_en(ld_en[1]), .t2_load_val(ld_val[1]), .t2_run_set(run_set[1]),
    .t2_run_clr(run_clr[1]),
    .t1_ack(t1_ack), .t2_ack(t2_ack)
  );

  assign run_clr[0] = 1'b0;
  assign cont[1]    = 1'b0;
  assign rl_val[1]  = '0;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    dit_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_core_n), .tick_en(tick_en),
      .load_en(ld_en[i]), .load_val(ld_val[i]),
      .run_set(run_set[i]), .run_clr(run_clr[i]),
      .cont_en(cont[i]), .reload_val(rl_val[i]),
      .cnt(cnt[i]), .running(running[i]), .expire(expire[i])
    );
  end

  assign t1_expire = expire[0];
  assign t2_expire = expire[1];

  // R3: latch-high write acknowledges but does not load
  a_r3_lhi_no_start: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en && addr == ADDR_W'(OFS_T1_LHI) && !(running[0] && tick_en) |=> $stable(cnt[0]));
  // R4: counter-high write starts timer 1
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en && addr == ADDR_W'(OFS_T1_CHI) |=> running[0] && t1_ack == 1'b0 || running[0]);
  // R10: timer 2 low write stops it
  a_r10_t2_stop: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en && addr == ADDR_W'(OFS_T2_LO) |=> !running[1]);
  // R9: read of counter high never acknowledges
  a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_en && !wr_en && addr == ADDR_W'(OFS_T1_CHI) |-> !t1_ack);
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic t1_ack, t2_ack, t1_expire, t2_expire;

  int checks = 0;
  int fails = 0;
  int cur = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;   // 0 rdata, 1 t1_ack, 2 t2_ack, 3 t1_expire, 4 t2_expire
    int    val;
    string tag;
    int    due;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .t1_ack(t1_ack), .t2_ack(t2_ack),
    .t1_expire(t1_expire), .t2_expire(t2_expire)
  );

  task automatic cyc(input bit w, input bit r, input logic [3:0] a,
                     input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
  endtask

  task automatic want(input int kind, input int val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag; it.due = cur;
    q.push_back(it);
  endtask

  // monitor: compare items due in this cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0 && q[0].due == cur) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.kind)
          0: act = int'(rdata);
          1: act = int'(t1_ack);
          2: act = int'(t2_ack);
          3: act = int'(t1_expire);
          default: act = int'(t2_expire);
        endcase
        checks++;
        if (act != it.val) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.val);
        end
      end
      cur++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 4'h0, 8'h00, 0);

    // R1 reset state
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h00, "R1 cnt1 lo");
    cyc(0, 1, 4'h5, 8'h00, 0); want(0, 8'h00, "R1 cnt1 hi"); want(1, 0, "R1 no ack");
    cyc(0, 1, 4'h9, 8'h00, 0); want(0, 8'h00, "R1 cnt2 hi"); want(3, 0, "R1 no expire");
    cyc(0, 1, 4'hB, 8'h00, 0); want(0, 8'h00, "R1 aux");

    // R2 latch low via both offsets
    cyc(1, 0, 4'h4, 8'h34, 0);
    cyc(0, 1, 4'h6, 8'h00, 0); want(0, 8'h34, "R2 latch lo via 0x4"); want(1, 0, "R2 no ack");
    cyc(1, 0, 4'h6, 8'h03, 0);
    cyc(0, 1, 4'h6, 8'h00, 0); want(0, 8'h03, "R2 latch lo via 0x6");
    // R3 latch high
    cyc(1, 0, 4'h7, 8'h00, 0); want(1, 1, "R3 ack on latch hi");
    cyc(0, 1, 4'h7, 8'h00, 0); want(0, 8'h00, "R2 latch hi read"); want(1, 0, "R2 no ack hi");
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h00, "R3 counter untouched"); want(1, 1, "R9 ack on read lo");

    // R4 start from latch, data ignored
    cyc(1, 0, 4'h5, 8'hFF, 0); want(1, 1, "R4 ack on start");
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h03, "R4 counter loaded");
    cyc(0, 1, 4'h5, 8'h00, 0); want(0, 8'h00, "R9 counter hi"); want(1, 0, "R9 hi no ack");

    // R5 decrement and hold
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h02, "R5 one tick");
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h02, "R5 hold without tick");

    // R6 one-shot expiry
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 0, "R6 no early expire");
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 0, "R6 no expire at one");
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 1, "R6 expire pulse"); want(0, 8'h00, "R6 rests at zero");
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 0, "R6 single-cycle pulse");
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 0, "R6 stopped no event"); want(0, 8'h00, "R6 stopped value");

    // R7 continuous mode
    cyc(1, 0, 4'h6, 8'h01, 0);
    cyc(1, 0, 4'h7, 8'h00, 0);
    cyc(1, 0, 4'h5, 8'h00, 0);
    cyc(1, 0, 4'hB, 8'h40, 0);
    cyc(0, 1, 4'hB, 8'h00, 0); want(0, 8'h40, "R8 aux readback");
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 1, "R7 first expiry");
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 0, "R7 between expiries");
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 1, "R7 second expiry"); want(0, 8'h01, "R7 reloaded");

    // R8 start from aux write
    cyc(1, 0, 4'hB, 8'h00, 0);
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 1, "R6 one-shot after leaving mode"); want(0, 8'h00, "R6 zero");
    cyc(0, 0, 4'h0, 8'h00, 1); want(3, 0, "R6 no event");
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 0, "R8 still stopped");
    cyc(1, 0, 4'hB, 8'h40, 0);
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 1, 4'h4, 8'h00, 0); want(3, 1, "R8 aux write started timer"); want(0, 8'h01, "R8 reload");
    cyc(1, 0, 4'hB, 8'h00, 0);

    // R12 load beats tick
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(1, 0, 4'h5, 8'h00, 1);
    cyc(0, 1, 4'h4, 8'h00, 0); want(0, 8'h01, "R12 load wins over tick");

    // R10 / R11 timer 2
    cyc(1, 0, 4'h8, 8'h02, 1);
    cyc(0, 1, 4'h9, 8'h00, 0); want(0, 8'h00, "R11 cnt2 hi"); want(2, 0, "R11 hi no ack");
    cyc(0, 1, 4'h8, 8'h00, 0); want(0, 8'h02, "R12 t2 load wins"); want(2, 1, "R11 ack on read lo");
    cyc(1, 0, 4'h9, 8'h01, 0); want(2, 1, "R10 ack on start");
    cyc(0, 1, 4'h9, 8'h00, 0); want(0, 8'h01, "R10 high byte added");
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 1, 4'h8, 8'h00, 0); want(0, 8'h01, "R10 t2 counts");
    cyc(0, 1, 4'h9, 8'h00, 0); want(0, 8'h01, "R10 t2 hi kept");
    cyc(1, 0, 4'h8, 8'h01, 0); want(2, 0, "R10 low write no ack");
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 1, 4'h8, 8'h00, 0); want(0, 8'h01, "R10 low write stopped t2");
    cyc(1, 0, 4'h9, 8'h00, 0);
    cyc(0, 0, 4'h0, 8'h00, 1);
    cyc(0, 0, 4'h0, 8'h00, 1); want(4, 0, "R6 t2 no early expire");
    cyc(0, 1, 4'h8, 8'h00, 0); want(4, 1, "R6 t2 expire"); want(0, 8'h00, "R6 t2 zero");
    cyc(0, 0, 4'h0, 8'h00, 1); want(4, 0, "R6 t2 single pulse");
    cyc(0, 1, 4'h8, 8'h00, 0); want(4, 0, "R6 t2 stays stopped");

    cyc(0, 0, 4'h0, 8'h00, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule